// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a fully associative buffer of address translations that turns 32-bit virtual addresses into real addresses. Each of its entries maps one page, and every entry picks its own page size from four choices (4 KB, 16 KB, 512 KB, 8 MB). The page size sets how many upper address bits take part in the compare and how many low bits pass straight through into the real address. Each entry also holds region attributes: guarded, read-only, cache-inhibit and write-through.

Software fills the buffer through a write port. A load goes either to an explicit slot number or to the slot held by an internal fill pointer. The fill pointer advances by one with each pointer load and wraps from the last slot back to slot 0. A single invalidate command empties the whole buffer. Lookups are combinational. A lookup presents an address, a read/write flag and a speculative flag, and gets back the outcome, the translated address and the attributes of the matching entry.

One instance serves data accesses. A second instance, built with the instruction parameter set, serves fetches. In that variant the entries are always executable and never write-through.

Top module: `mptlb_top`

## Requirements
- R1: After reset every entry is invalid and the fill pointer is 0, so any lookup reports miss.
- R2: The page size code is decoded as 00 = 4 KB (12 offset bits), 10 = 16 KB (14 bits), 01 = 512 KB (19 bits), 11 = 8 MB (23 bits). A valid entry matches when the lookup address equals the stored virtual base in every bit above that entry's offset.
- R3: On a match, the real address is the stored real base in the bits above the offset, joined with the lookup address bits inside the offset. Stored base bits below the page size are ignored in both compare and translation.
- R4: When no valid entry matches, miss is 1. In that case hit, prot_fault, spec_block, multi_hit, the real address and all attribute outputs are 0.
- R5: A load with wr_en=1 and wr_use_ptr=0 writes slot wr_idx and marks it valid, replacing what the slot held before. Lookups see the new contents from the next cycle.
- R6: A load with wr_en=1 and wr_use_ptr=1 writes the slot named by the fill pointer. The pointer then advances by one and wraps from 31 to 0. Loads by explicit slot number leave the pointer unchanged.
- R7: inv_all clears every entry's valid bit and resets the fill pointer to 0 in one cycle. A load presented in the same cycle is dropped.
- R8: A write lookup (lk_write=1) that matches a read-only entry gives prot_fault=1 and hit=0. A read lookup of the same entry gives hit=1 with lk_ro=1.
- R9: A speculative lookup (lk_spec=1) that matches a guarded entry gives spec_block=1 and hit=0. The same lookup without lk_spec gives hit=1.
- R10: On a match, the entry's cache-inhibit and write-through bits appear unchanged on lk_ci and lk_wt.
- R11: When several valid entries match, the lowest-numbered slot supplies the result and multi_hit is 1. With a single match, multi_hit is 0.
- R12: In the instruction variant (IS_INSTR=1), the read-only and write-through bits are stored as 0, so prot_fault never rises and lk_wt stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_use_ptr | input | 1 | 1: load at fill pointer; 0: load at wr_idx |
| wr_idx | input | 5 | Explicit slot number |
| wr_vbase | input | 32 | Virtual page base |
| wr_rbase | input | 32 | Real page base |
| wr_size | input | 2 | Page size code |
| wr_guard | input | 1 | Guarded attribute |
| wr_ro | input | 1 | Read-only attribute |
| wr_ci | input | 1 | Cache-inhibit attribute |
| wr_wt | input | 1 | Write-through attribute |
| inv_all | input | 1 | Invalidate every entry |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is a store |
| lk_spec | input | 1 | Lookup is speculative |
| hit | output | 1 | Permitted translation found |
| miss | output | 1 | No valid entry matched |
| prot_fault | output | 1 | Store to read-only page |
| spec_block | output | 1 | Speculative access to guarded page |
| multi_hit | output | 1 | More than one entry matched |
| lk_raddr | output | 32 | Translated real address |
| lk_guard | output | 1 | Guarded bit of matching entry |
| lk_ro | output | 1 | Read-only bit of matching entry |
| lk_ci | output | 1 | Cache-inhibit bit of matching entry |
| lk_wt | output | 1 | Write-through bit of matching entry |

## Verification
On every cycle, the assertions check that the four lookup outcomes are mutually consistent and that a miss drives all outputs to zero. They also check that faults and blocks arise only from the matching attribute and access kind, that the low 12 address bits always pass through, and that the cycle after reset or an invalidate sees an empty buffer. The concrete translations for each page size, the choice of the lowest slot among overlapping entries, the wrap of the fill pointer, slot replacement and the instruction variant's sanitised attributes depend on loaded contents. Only the bench's directed scenarios show those.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W = 32;

    localparam int OFS_4K   = 12;
    localparam int OFS_16K  = 14;
    localparam int OFS_512K = 19;
    localparam int OFS_8M   = 23;

    typedef enum logic [1:0] {
        SZ_4K   = 2'b00,
        SZ_512K = 2'b01,
        SZ_16K  = 2'b10,
        SZ_8M   = 2'b11
    } page_sz_e;

    typedef struct packed {
        logic            valid;
        logic [VA_W-1:0] vbase;
        logic [VA_W-1:0] rbase;
        page_sz_e        size;
        logic            guard;
        logic            ro;
        logic            ci;
        logic            wt;
    } tlb_entry_t;

    // mask of the in-page offset bits for a size code
    function automatic logic [VA_W-1:0] ofs_mask(page_sz_e sz);
        logic [VA_W-1:0] one;
        int              nbits;
        one = {{(VA_W-1){1'b0}}, 1'b1};
        case (sz)
            SZ_4K:   nbits = OFS_4K;
            SZ_16K:  nbits = OFS_16K;
            SZ_512K: nbits = OFS_512K;
            default: nbits = OFS_8M;
        endcase
        return (one << nbits) - one;
    endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 32,
    parameter bit IS_INSTR = 1'b0,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_use_ptr,
    input  logic [IDX_W-1:0]          wr_idx,
    input  tlb_entry_t                wr_entry,
    input  logic                      inv_all,
    output tlb_entry_t [ENTRIES-1:0]  entries
);
    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]         ptr;
    } store_t;

    store_t     st_d, st_q;
    tlb_entry_t load_ent;
    logic [IDX_W-1:0] slot;

    // the variant picks how attributes are taken in
    generate
        if (IS_INSTR) begin : g_instr
            always_comb begin
                load_ent       = wr_entry;
                load_ent.ro    = 1'b0;
                load_ent.wt    = 1'b0;
                load_ent.valid = 1'b1;
            end
        end else begin : g_data
            always_comb begin
                load_ent       = wr_entry;
                load_ent.valid = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        slot = wr_use_ptr ? st_q.ptr : wr_idx;
        if (inv_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ent[i].valid = 1'b0;
            end
            st_d.ptr = '0;
        end else if (wr_en) begin
            st_d.ent[slot] = load_ent;
            if (wr_use_ptr) begin
                if (st_q.ptr == IDX_W'(ENTRIES - 1)) begin
                    st_d.ptr = '0;
                end else begin
                    st_d.ptr = st_q.ptr + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign entries = st_q.ent;
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  tlb_entry_t [ENTRIES-1:0] entries,
    input  logic [VA_W-1:0]          vaddr,
    output logic [ENTRIES-1:0]       match
);
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            logic [VA_W-1:0] keep;
            assign keep     = ~ofs_mask(entries[g].size);
            assign match[g] = entries[g].valid &&
                              ((vaddr & keep) == (entries[g].vbase & keep));
        end
    endgenerate
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  tlb_entry_t [ENTRIES-1:0] entries,
    input  logic [ENTRIES-1:0]       match,
    output tlb_entry_t               sel,
    output logic                     any,
    output logic                     multi
);
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel = entries[i];
            end
        end
    end

    assign any   = |match;
    assign multi = (match & (match - ENTRIES'(1))) != '0;
endmodule

// File: rtl/mptlb_top.sv
module mptlb_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES  = 32,
    parameter bit IS_INSTR = 1'b0,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_use_ptr,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_vbase,
    input  logic [VA_W-1:0]   wr_rbase,
    input  logic [1:0]        wr_size,
    input  logic              wr_guard,
    input  logic              wr_ro,
    input  logic              wr_ci,
    input  logic              wr_wt,
    input  logic              inv_all,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    input  logic              lk_spec,
    output logic              hit,
    output logic              miss,
    output logic              prot_fault,
    output logic              spec_block,
    output logic              multi_hit,
    output logic [VA_W-1:0]   lk_raddr,
    output logic              lk_guard,
    output logic              lk_ro,
    output logic              lk_ci,
    output logic              lk_wt
);
    tlb_entry_t               wr_entry;
    tlb_entry_t [ENTRIES-1:0] entries;
    logic [ENTRIES-1:0]       match;
    tlb_entry_t               sel;
    logic                     any;
    logic                     multi;
    logic [VA_W-1:0]          omask;
    logic                     ro_eff;

    always_comb begin
        wr_entry       = '0;
        wr_entry.vbase = wr_vbase;
        wr_entry.rbase = wr_rbase;
        wr_entry.size  = page_sz_e'(wr_size);
        wr_entry.guard = wr_guard;
        wr_entry.ro    = wr_ro;
        wr_entry.ci    = wr_ci;
        wr_entry.wt    = wr_wt;
    end

    tlb_store #(.ENTRIES(ENTRIES), .IS_INSTR(IS_INSTR)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_use_ptr (wr_use_ptr),
        .wr_idx     (wr_idx),
        .wr_entry   (wr_entry),
        .inv_all    (inv_all),
        .entries    (entries)
    );

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .entries (entries),
        .vaddr   (lk_vaddr),
        .match   (match)
    );

    tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
        .entries (entries),
        .match   (match),
        .sel     (sel),
        .any     (any),
        .multi   (multi)
    );

    assign omask  = ofs_mask(sel.size);
    assign ro_eff = IS_INSTR ? 1'b0 : sel.ro;

    always_comb begin
        miss       = ~any;
        spec_block = any & lk_spec & sel.guard;
        prot_fault = any & lk_write & ro_eff;
        hit        = any & ~spec_block & ~prot_fault;
        multi_hit  = any & multi;
        lk_raddr   = any ? ((sel.rbase & ~omask) | (lk_vaddr & omask)) : '0;
        lk_guard   = any & sel.guard;
        lk_ro      = any & sel.ro;
        lk_ci      = any & sel.ci;
        lk_wt      = any & sel.wt;
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        inv_all,
    input logic [31:0] lk_vaddr,
    input logic        lk_write,
    input logic        lk_spec,
    input logic        hit,
    input logic        miss,
    input logic        prot_fault,
    input logic        spec_block,
    input logic        multi_hit,
    input logic [31:0] lk_raddr,
    input logic        lk_guard,
    input logic        lk_ro,
    input logic        lk_ci,
    input logic        lk_wt
);
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> miss);

    p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (lk_raddr[11:0] == lk_vaddr[11:0]));

    p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (lk_raddr == 32'd0 && !hit && !prot_fault && !spec_block &&
                  !multi_hit && !lk_guard && !lk_ro && !lk_ci && !lk_wt));

    p_inv_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> miss);

    p_fault_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (lk_write && lk_ro && !hit));

    p_block_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spec_block |-> (lk_spec && lk_guard && !hit));

    p_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss == !(hit || prot_fault || spec_block));

    p_multi_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> !miss);
endmodule

bind mptlb_top tlb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_all    (inv_all),
    .lk_vaddr   (lk_vaddr),
    .lk_write   (lk_write),
    .lk_spec    (lk_spec),
    .hit        (hit),
    .miss       (miss),
    .prot_fault (prot_fault),
    .spec_block (spec_block),
    .multi_hit  (multi_hit),
    .lk_raddr   (lk_raddr),
    .lk_guard   (lk_guard),
    .lk_ro      (lk_ro),
    .lk_ci      (lk_ci),
    .lk_wt      (lk_wt)
);

// File: tb/tb_mptlb_top.sv
module tb_mptlb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_use_ptr = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_vbase = '0, wr_rbase = '0;
    logic [1:0]  wr_size = '0;
    logic        wr_guard = 1'b0, wr_ro = 1'b0, wr_ci = 1'b0, wr_wt = 1'b0;
    logic        inv_all = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0, lk_spec = 1'b0;

    logic hit, miss, prot_fault, spec_block, multi_hit, lk_guard, lk_ro, lk_ci, lk_wt;
    logic [31:0] lk_raddr;
    logic ihit, imiss, ipf, isb, imh, ig, iro, ici, iwt;
    logic [31:0] iraddr;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mptlb_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_use_ptr(wr_use_ptr),
        .wr_idx(wr_idx), .wr_vbase(wr_vbase), .wr_rbase(wr_rbase), .wr_size(wr_size),
        .wr_guard(wr_guard), .wr_ro(wr_ro), .wr_ci(wr_ci), .wr_wt(wr_wt),
        .inv_all(inv_all), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_spec(lk_spec),
        .hit(hit), .miss(miss), .prot_fault(prot_fault), .spec_block(spec_block),
        .multi_hit(multi_hit), .lk_raddr(lk_raddr), .lk_guard(lk_guard),
        .lk_ro(lk_ro), .lk_ci(lk_ci), .lk_wt(lk_wt)
    );

    mptlb_top #(.IS_INSTR(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_use_ptr(wr_use_ptr),
        .wr_idx(wr_idx), .wr_vbase(wr_vbase), .wr_rbase(wr_rbase), .wr_size(wr_size),
        .wr_guard(wr_guard), .wr_ro(wr_ro), .wr_ci(wr_ci), .wr_wt(wr_wt),
        .inv_all(inv_all), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_spec(lk_spec),
        .hit(ihit), .miss(imiss), .prot_fault(ipf), .spec_block(isb),
        .multi_hit(imh), .lk_raddr(iraddr), .lk_guard(ig),
        .lk_ro(iro), .lk_ci(ici), .lk_wt(iwt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic load(input logic use_ptr, input logic [4:0] idx, input logic [31:0] vb,
                        input logic [31:0] rb, input logic [1:0] sz, input logic g,
                        input logic ro, input logic ci, input logic wt);
        @(negedge clk);
        wr_en = 1'b1; wr_use_ptr = use_ptr; wr_idx = idx; wr_vbase = vb; wr_rbase = rb;
        wr_size = sz; wr_guard = g; wr_ro = ro; wr_ci = ci; wr_wt = wt;
        @(negedge clk);
        wr_en = 1'b0; wr_use_ptr = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic wr, input logic sp);
        @(negedge clk);
        lk_vaddr = va; lk_write = wr; lk_spec = sp;
        #1;
    endtask

    // expects a plain permitted hit with the given real address
    task automatic expect_hit(input string req, input logic [31:0] va, input logic [31:0] ra);
        look(va, 1'b0, 1'b0);
        chk({req, " hit"}, {31'd0, hit}, 32'd1);
        chk({req, " raddr"}, lk_raddr, ra);
    endtask

    task automatic expect_miss(input string req, input logic [31:0] va);
        look(va, 1'b0, 1'b0);
        chk({req, " miss"}, {31'd0, miss}, 32'd1);
        chk({req, " raddr zero"}, lk_raddr, 32'd0);
    endtask

    task automatic t_reset;
        look(32'h0040_0ABC, 1'b0, 1'b0);
        chk("R1 miss after reset", {31'd0, miss}, 32'd1);
        chk("R4 hit low on miss", {31'd0, hit}, 32'd0);
        chk("R4 attrs zero on miss", {28'd0, lk_guard, lk_ro, lk_ci, lk_wt}, 32'd0);
    endtask

    task automatic t_sizes;
        load(1'b0, 5'd0, 32'h0040_0000, 32'h0120_0000, 2'b00, 0, 0, 0, 0);
        load(1'b0, 5'd1, 32'h0080_0123, 32'h0300_0FFF, 2'b10, 0, 0, 0, 0);
        load(1'b0, 5'd2, 32'h1000_0000, 32'h2008_0000, 2'b01, 0, 0, 0, 0);
        load(1'b0, 5'd3, 32'h4000_0000, 32'h5080_0000, 2'b11, 0, 0, 1, 1);
        expect_hit("R2 4K", 32'h0040_0ABC, 32'h0120_0ABC);
        expect_miss("R2 4K edge", 32'h0040_1000);
        expect_hit("R3 16K unaligned bases", 32'h0080_3456, 32'h0300_3456);
        expect_miss("R2 16K edge", 32'h0080_4000);
        expect_hit("R2 512K", 32'h1007_FFFC, 32'h200F_FFFC);
        expect_miss("R2 512K edge", 32'h1008_0000);
        expect_hit("R3 8M", 32'h407F_0010, 32'h50FF_0010);
        expect_miss("R2 8M edge", 32'h4080_0000);
        look(32'h4000_0000, 1'b0, 1'b0);
        chk("R10 ci passed", {31'd0, lk_ci}, 32'd1);
        chk("R10 wt passed", {31'd0, lk_wt}, 32'd1);
        chk("R12 instr wt forced 0", {31'd0, iwt}, 32'd0);
        chk("R12 instr ci kept", {31'd0, ici}, 32'd1);
    endtask

    task automatic t_ro;
        load(1'b0, 5'd4, 32'h6000_0000, 32'h7000_0000, 2'b00, 0, 1, 0, 0);
        look(32'h6000_0010, 1'b0, 1'b0);
        chk("R8 read of ro hits", {31'd0, hit}, 32'd1);
        chk("R8 ro reported", {31'd0, lk_ro}, 32'd1);
        look(32'h6000_0010, 1'b1, 1'b0);
        chk("R8 write faults", {31'd0, prot_fault}, 32'd1);
        chk("R8 write no hit", {31'd0, hit}, 32'd0);
        chk("R12 instr no fault", {31'd0, ipf}, 32'd0);
        chk("R12 instr hit", {31'd0, ihit}, 32'd1);
        chk("R12 instr ro 0", {31'd0, iro}, 32'd0);
    endtask

    task automatic t_guard;
        load(1'b0, 5'd5, 32'h6100_0000, 32'h7100_0000, 2'b00, 1, 0, 0, 0);
        look(32'h6100_0020, 1'b0, 1'b1);
        chk("R9 spec blocked", {31'd0, spec_block}, 32'd1);
        chk("R9 spec no hit", {31'd0, hit}, 32'd0);
        look(32'h6100_0020, 1'b0, 1'b0);
        chk("R9 nonspec hit", {31'd0, hit}, 32'd1);
        chk("R9 guard out", {31'd0, lk_guard}, 32'd1);
    endtask

    task automatic t_multi;
        load(1'b0, 5'd6, 32'h0000_0000, 32'h0A00_0000, 2'b11, 0, 0, 0, 0);
        load(1'b0, 5'd7, 32'h0000_5000, 32'h0B00_0000, 2'b00, 0, 0, 0, 0);
        expect_hit("R11 lowest slot wins", 32'h0000_5004, 32'h0A00_5004);
        chk("R11 multi flag", {31'd0, multi_hit}, 32'd1);
        load(1'b0, 5'd6, 32'h7F00_0000, 32'h0C00_0000, 2'b00, 0, 0, 0, 0);
        expect_hit("R5 replaced slot", 32'h0000_5004, 32'h0B00_0004);
        chk("R11 single match", {31'd0, multi_hit}, 32'd0);
        expect_miss("R5 old mapping gone", 32'h0000_1000);
        expect_hit("R5 new mapping", 32'h7F00_0008, 32'h0C00_0008);
    endtask

    task automatic t_inval;
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        expect_miss("R7 invalidated", 32'h0040_0ABC);
        expect_miss("R7 invalidated 8M", 32'h407F_0010);
        @(negedge clk);
        inv_all = 1'b1; wr_en = 1'b1; wr_use_ptr = 1'b0; wr_idx = 5'd9;
        wr_vbase = 32'hE000_0000; wr_rbase = 32'hE000_0000; wr_size = 2'b00;
        @(negedge clk);
        inv_all = 1'b0; wr_en = 1'b0;
        expect_miss("R7 same-cycle load dropped", 32'hE000_0000);
    endtask

    task automatic t_ptr;
        for (int k = 0; k < 33; k++) begin
            load(1'b1, 5'd0, 32'h8000_0000 + k * 32'h1000, 32'h9000_0000 + k * 32'h1000,
                 2'b00, 0, 0, 0, 0);
        end
        expect_miss("R6 wrap overwrote slot 0", 32'h8000_0000);
        expect_hit("R6 33rd load", 32'h8002_0000, 32'h9002_0000);
        expect_hit("R6 slot 31", 32'h8001_F000, 32'h9001_F000);
        load(1'b0, 5'd10, 32'hC000_0000, 32'hD000_0000, 2'b00, 0, 0, 0, 0);
        load(1'b1, 5'd0, 32'h8002_1000, 32'h9002_1000, 2'b00, 0, 0, 0, 0);
        expect_miss("R5 slot 10 replaced", 32'h8000_A000);
        expect_hit("R5 explicit load", 32'hC000_0004, 32'hD000_0004);
        expect_miss("R6 pointer at slot 1", 32'h8000_1000);
        expect_hit("R6 pointer load", 32'h8002_1000, 32'h9002_1000);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sizes();
        t_ro();
        t_guard();
        t_multi();
        t_inval();
        t_ptr();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule